// File: doc/BRIEF.md
# Modem Host Register Interface

This block is the host-facing register set of a modem peripheral. A microcontroller reaches the same four 8-bit registers through either of two paths. The first is a multiplexed address/data bus: an address-latch strobe captures the register address and the chip-select level on its falling edge, and separate active-low read and write strobes move the data. The second is a serial command mode, chosen by holding the latch strobe high and chip select low. In that mode bus bit 7 carries the data one bit at a time, least significant bit first, timed by the falling edges of a shift clock, and bus bits 2..0 carry the address.

The register set holds two control registers, a tone register and a read-only detect register. Detect flags arrive as one-cycle pulses from the surrounding modem logic. Each flag sets a sticky bit and pulls the active-low interrupt output low. Completing a read of the detect register clears the flags and releases the interrupt. A write that moves the transmit-enable bit of control register 0 from 0 to 1 while tone mode is selected produces a one-cycle tone-start pulse. Every host pin is sampled by the fast system clock through a two-flop synchronizer, and all edges are found in that clock domain.

Top module: `modem_regif`

## Requirements
- R1: A synchronous active-high reset clears control register 0, control register 1 (including its clock-select bit 7, whose default 0 means crystal clock), the tone register and the detect register, and sets irq_n_o high.
- R2: On a falling edge of ale_i, ad_i[2:0] is captured as the register address and cs_n_i as the select level. Address 0 is control 0, 1 is control 1, 2 is detect and 3 is tone. Addresses 4 to 7 read as 0 and ignore writes.
- R3: In bus mode a rising edge of wr_n_i stores ad_i into the latched register, but only when the latched select was low. Otherwise nothing changes.
- R4: In bus mode, ad_oe_o is all ones and ad_o carries the addressed register only while rd_n_i is low and the latched select is low. At all other times ad_oe_o is 0.
- R5: Writes to the detect register, on either path, leave it unchanged.
- R6: A pulse on any det_i bit sets that detect bit and drives irq_n_o low on the next clock. Both stay set until a read of the detect register completes (rd_n_i rises) or a reset occurs. A flag that arrives in the same cycle as that clear stays set and keeps irq_n_o low.
- R7: While ale_i is high and cs_n_i is low the block is in serial mode. ad_i[2:0] is the address, ad_i[7] is write data, and ad_o[7] is read data with ad_oe_o = 8'h80.
- R8: A serial read loads the addressed register when rd_n_i falls and presents bit 0 on ad_o[7]. Each of the next seven falling sclk_i edges presents the next higher bit.
- R9: A serial write shifts ad_i[7] in on eight falling sclk_i edges while rd_n_i is high, first bit as bit 0. A rising edge of wr_n_i then stores the eight bits into the addressed register.
- R10: A write that changes control register 0 bit 1 from 0 to 1, while tone register bit 4 is 1, produces exactly one one-cycle pulse on tone_start_o. No pulse occurs if bit 4 is 0 or bit 1 was already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all host pins |
| rst | input | 1 | Synchronous active-high reset |
| ale_i | input | 1 | Address latch strobe; held high for serial mode |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| sclk_i | input | 1 | Serial shift clock (falling edge active) |
| ad_i | input | 8 | Address/data bus inbound |
| ad_o | output | 8 | Address/data bus outbound |
| ad_oe_o | output | 8 | Per-bit output enable for ad_o |
| det_i | input | 8 | One-cycle detect flag pulses, system clock domain |
| irq_n_o | output | 1 | Active-low interrupt |
| ctl0_o | output | 8 | Control register 0 contents |
| ctl1_o | output | 8 | Control register 1 contents |
| tone_o | output | 8 | Tone register contents |
| tone_start_o | output | 1 | One-cycle tone generation start pulse |

## Verification
The hardest case to reach from the ports is a detect flag that lands in exactly the clock cycle in which a completed detect read clears the register. The read strobe's rising edge passes through two synchronizer flops and an edge flop before it clears the register. The stimulus therefore releases rd_n_i and then drives the det_i pulse two falling clock edges later, so that the pulse and the clear meet at the same rising edge. A later read and the interrupt level then show whether the new flag survived. The serial paths are exercised by bit-serial tasks that cross into and out of bus mode between transfers. Those tasks also check that only bus bit 7 is driven.

// File: rtl/modem_regif_pkg.sv
package modem_regif_pkg;
  localparam int ADR_CTL0 = 0;
  localparam int ADR_CTL1 = 1;
  localparam int ADR_DET  = 2;
  localparam int ADR_TONE = 3;

  localparam int TXEN_BIT  = 1;
  localparam int TMODE_BIT = 4;
  localparam int CKSEL_BIT = 7;

  localparam int NUM_PINS = 5;
  // idle levels of {sclk, wr_n, rd_n, cs_n, ale}
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 5'b01110;
endpackage

// File: rtl/modem_regif_sync.sv
module modem_regif_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/modem_regif_host.sv
module modem_regif_host #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          sclk,
  input  logic [DW-1:0] ad,
  input  logic [DW-1:0] rd_data,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] acc_addr,
  output logic          rd_done,
  output logic [DW-1:0] ad_o,
  output logic [DW-1:0] ad_oe_o
);
  localparam logic [DW-1:0] SER_OE = {1'b1, {(DW-1){1'b0}}};

  logic ale_q, rd_q, wr_q, sclk_q;
  logic ale_fall, rd_fall, rd_rise, wr_rise, sclk_fall;
  logic ser_mode, access_ok, cs_act;
  logic [AW-1:0] addr_lat;
  logic [DW-1:0] sin_q, sout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q  <= 1'b0;
      rd_q   <= 1'b1;
      wr_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      ale_q  <= ale;
      rd_q   <= rd_n;
      wr_q   <= wr_n;
      sclk_q <= sclk;
    end
  end

  assign ale_fall  = ale_q & ~ale;
  assign rd_fall   = rd_q & ~rd_n;
  assign rd_rise   = ~rd_q & rd_n;
  assign wr_rise   = ~wr_q & wr_n;
  assign sclk_fall = sclk_q & ~sclk;
  assign ser_mode  = ale & ~cs_n;

  // address and select capture for the multiplexed bus
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lat <= '0;
      cs_act   <= 1'b0;
    end else if (ale_fall) begin
      addr_lat <= ad[AW-1:0];
      cs_act   <= ~cs_n;
    end
  end

  assign access_ok = ser_mode | cs_act;
  assign acc_addr  = ser_mode ? ad[AW-1:0] : addr_lat;
  assign wr_stb    = wr_rise & access_ok;
  assign rd_done   = rd_rise & access_ok;
  assign wr_data   = ser_mode ? sin_q : ad;

  // serial shifters, least significant bit first
  always_ff @(posedge clk) begin
    if (rst) begin
      sin_q  <= '0;
      sout_q <= '0;
    end else begin
      if (ser_mode && sclk_fall && rd_n)
        sin_q <= {ad[DW-1], sin_q[DW-1:1]};
      if (ser_mode && rd_fall)
        sout_q <= rd_data;
      else if (ser_mode && sclk_fall && !rd_n)
        sout_q <= {1'b0, sout_q[DW-1:1]};
    end
  end

  // registered bus drive
  always_ff @(posedge clk) begin
    if (rst) begin
      ad_o    <= '0;
      ad_oe_o <= '0;
    end else if (ser_mode) begin
      ad_o    <= rd_n ? '0 : {sout_q[0], {(DW-1){1'b0}}};
      ad_oe_o <= rd_n ? '0 : SER_OE;
    end else begin
      ad_o    <= (cs_act && !rd_n) ? rd_data : '0;
      ad_oe_o <= (cs_act && !rd_n) ? '1 : '0;
    end
  end
endmodule

// File: rtl/modem_regif_regs.sv
module modem_regif_regs
  import modem_regif_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_done,
  input  logic [DW-1:0] det_set,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ctl0,
  output logic [DW-1:0] ctl1,
  output logic [DW-1:0] tone,
  output logic          irq_n,
  output logic          tone_start
);
  logic [DW-1:0] det_q;
  logic det_clr, wr_ctl0, wr_ctl1, wr_tone;

  assign det_clr = rd_done && (acc_addr == AW'(ADR_DET));
  assign wr_ctl0 = wr_stb && (acc_addr == AW'(ADR_CTL0));
  assign wr_ctl1 = wr_stb && (acc_addr == AW'(ADR_CTL1));
  assign wr_tone = wr_stb && (acc_addr == AW'(ADR_TONE));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl0 <= '0;
      ctl1 <= '0;
      tone <= '0;
    end else begin
      if (wr_ctl0) ctl0 <= wr_data;
      if (wr_ctl1) ctl1 <= wr_data;
      if (wr_tone) tone <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tone_start <= 1'b0;
    else tone_start <= wr_ctl0 && wr_data[TXEN_BIT] && !ctl0[TXEN_BIT] && tone[TMODE_BIT];
  end

  // sticky flags: a new flag wins over a simultaneous read-clear
  always_ff @(posedge clk) begin
    if (rst) begin
      det_q <= '0;
      irq_n <= 1'b1;
    end else begin
      det_q <= (det_clr ? '0 : det_q) | det_set;
      if (|det_set) irq_n <= 1'b0;
      else if (det_clr) irq_n <= 1'b1;
    end
  end

  always_comb begin
    case (acc_addr)
      AW'(ADR_CTL0): rd_data = ctl0;
      AW'(ADR_CTL1): rd_data = ctl1;
      AW'(ADR_DET):  rd_data = det_q;
      AW'(ADR_TONE): rd_data = tone;
      default:       rd_data = '0;
    endcase
  end
endmodule

// File: rtl/modem_regif.sv
module modem_regif
  import modem_regif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic [DATA_W-1:0] ad_oe_o,
  input  logic [DATA_W-1:0] det_i,
  output logic              irq_n_o,
  output logic [DATA_W-1:0] ctl0_o,
  output logic [DATA_W-1:0] ctl1_o,
  output logic [DATA_W-1:0] tone_o,
  output logic              tone_start_o
);
  localparam int SW = DATA_W + NUM_PINS;
  localparam logic [SW-1:0] SYNC_RST = {{DATA_W{1'b0}}, PIN_IDLE};

  logic [SW-1:0] pins_s;
  logic [DATA_W-1:0] ad_s, rd_data, wr_data;
  logic ale_s, cs_s, rd_s, wr_s, sclk_s;
  logic wr_stb, rd_done;
  logic [ADDR_W-1:0] acc_addr;

  modem_regif_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ad_i, sclk_i, wr_n_i, rd_n_i, cs_n_i, ale_i}),
    .q   (pins_s)
  );

  assign {ad_s, sclk_s, wr_s, rd_s, cs_s, ale_s} = pins_s;

  modem_regif_host #(.DW(DATA_W), .AW(ADDR_W)) u_host (
    .clk      (clk),
    .rst      (rst),
    .ale      (ale_s),
    .cs_n     (cs_s),
    .rd_n     (rd_s),
    .wr_n     (wr_s),
    .sclk     (sclk_s),
    .ad       (ad_s),
    .rd_data  (rd_data),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .acc_addr (acc_addr),
    .rd_done  (rd_done),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o)
  );

  modem_regif_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .acc_addr   (acc_addr),
    .wr_data    (wr_data),
    .rd_done    (rd_done),
    .det_set    (det_i),
    .rd_data    (rd_data),
    .ctl0       (ctl0_o),
    .ctl1       (ctl1_o),
    .tone       (tone_o),
    .irq_n      (irq_n_o),
    .tone_start (tone_start_o)
  );
endmodule

// File: rtl/modem_regif_chk.sv
module modem_regif_chk
  import modem_regif_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_s,
  input logic          wr_stb,
  input logic          rd_done,
  input logic [AW-1:0] acc_addr,
  input logic [DW-1:0] det_i,
  input logic          irq_n_o,
  input logic          tone_start_o,
  input logic [DW-1:0] ad_oe_o,
  input logic [DW-1:0] ctl0_o,
  input logic [DW-1:0] ctl1_o,
  input logic [DW-1:0] tone_o
);
  localparam logic [DW-1:0] SER_OE = {1'b1, {(DW-1){1'b0}}};

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctl0_o == '0 && ctl1_o == '0 && tone_o == '0 && irq_n_o));

  a_r6_flag_raises_irq: assert property (@(posedge clk) disable iff (rst)
    (|det_i) |=> !irq_n_o);

  a_r6_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (!irq_n_o && !(rd_done && acc_addr == AW'(ADR_DET))) |=> !irq_n_o);

  a_r10_tone_one_cycle: assert property (@(posedge clk) disable iff (rst)
    tone_start_o |=> !tone_start_o);

  a_r10_tone_cause: assert property (@(posedge clk) disable iff (rst)
    tone_start_o |-> (ctl0_o[TXEN_BIT] && tone_o[TMODE_BIT]));

  a_r4_oe_shape: assert property (@(posedge clk) disable iff (rst)
    (ad_oe_o != '0) |-> (ad_oe_o == '1 || ad_oe_o == SER_OE));

  a_r4_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
    (ad_oe_o != '0) |-> $past(!rd_s));

  a_r3_ctl_change_needs_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctl0_o) |-> $past(wr_stb));
endmodule

bind modem_regif modem_regif_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_s         (rd_s),
  .wr_stb       (wr_stb),
  .rd_done      (rd_done),
  .acc_addr     (acc_addr),
  .det_i        (det_i),
  .irq_n_o      (irq_n_o),
  .tone_start_o (tone_start_o),
  .ad_oe_o      (ad_oe_o),
  .ctl0_o       (ctl0_o),
  .ctl1_o       (ctl1_o),
  .tone_o       (tone_o)
);

// File: tb/sim_modem_regif.sv
module sim_modem_regif;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sclk = 1'b0;
  logic [7:0] ad = 8'h00, det = 8'h00;
  logic [7:0] ad_o, ad_oe, ctl0, ctl1, tone;
  logic irq_n, tstart;

  always #5 clk = ~clk;

  modem_regif u0 (
    .clk(clk), .rst(rst), .ale_i(ale), .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .sclk_i(sclk), .ad_i(ad), .ad_o(ad_o), .ad_oe_o(ad_oe), .det_i(det),
    .irq_n_o(irq_n), .ctl0_o(ctl0), .ctl1_o(ctl1), .tone_o(tone), .tone_start_o(tstart)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  int pulses = 0, exp_pulses = 0;
  bit settled = 1'b0;
  logic [7:0] m_ctl0 = 0, m_ctl1 = 0, m_tone = 0, m_det = 0;
  logic m_irq_n = 1'b1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // reference model compared on every clock while no transfer is in flight
  always @(negedge clk) begin
    cyc++;
    if (tstart) pulses++;
    if (settled && !rst) begin
      chk("R3 ctl0", ctl0, m_ctl0);
      chk("R3 ctl1", ctl1, m_ctl1);
      chk("R3 tone", tone, m_tone);
      chk("R6 irq_n", irq_n, m_irq_n);
      chk("R4 idle oe", ad_oe, 0);
      chk("R10 tone pulses", pulses, exp_pulses);
    end
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ctl0;
      3'd1: return m_ctl1;
      3'd2: return m_det;
      3'd3: return m_tone;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_wr(input logic [2:0] a, input logic [7:0] d);
    if (a == 3'd0 && d[1] && !m_ctl0[1] && m_tone[4]) exp_pulses++;
    case (a)
      3'd0: m_ctl0 = d;
      3'd1: m_ctl1 = d;
      3'd3: m_tone = d;
      default: ;
    endcase
  endfunction

  task automatic latch(input logic [2:0] a, input bit sel);
    ale = 1'b1; ad = {5'b0, a}; cs_n = !sel; wt(4);
    ale = 1'b0; wt(4); cs_n = 1'b1;
  endtask

  task automatic par_write(input logic [2:0] a, input logic [7:0] d, input bit sel);
    settled = 0;
    latch(a, sel);
    ad = d; wr_n = 1'b0; wt(4);
    wr_n = 1'b1; wt(5);
    if (sel) model_wr(a, d);
    settled = 1;
  endtask

  task automatic par_read(input logic [2:0] a, input bit sel, input string tag);
    logic [7:0] e;
    settled = 0;
    e = model_rd(a);
    latch(a, sel);
    rd_n = 1'b0; wt(5);
    chk({tag, " oe"}, ad_oe, sel ? 8'hFF : 8'h00);
    if (sel) chk({tag, " data"}, ad_o, e);
    rd_n = 1'b1; wt(5);
    if (sel && a == 3'd2) begin m_det = 0; m_irq_n = 1'b1; end
    settled = 1;
  endtask

  task automatic ser_write(input logic [2:0] a, input logic [7:0] d);
    settled = 0;
    ale = 1'b1; cs_n = 1'b0; ad = {5'b0, a}; wt(4);
    for (int i = 0; i < 8; i++) begin
      ad = {d[i], 4'b0, a}; wt(3);
      sclk = 1'b1; wt(3);
      sclk = 1'b0; wt(3);
    end
    wr_n = 1'b0; wt(3);
    wr_n = 1'b1; wt(5);
    model_wr(a, d);
    settled = 1;
  endtask

  task automatic ser_read(input logic [2:0] a, input string tag);
    logic [7:0] e, got;
    settled = 0;
    e = model_rd(a);
    ale = 1'b1; cs_n = 1'b0; ad = {5'b0, a}; wt(4);
    rd_n = 1'b0; wt(5);
    chk("R7 serial oe only bit 7", ad_oe, 8'h80);
    got[0] = ad_o[7];
    for (int i = 1; i < 8; i++) begin
      sclk = 1'b1; wt(3);
      sclk = 1'b0; wt(5);
      got[i] = ad_o[7];
    end
    rd_n = 1'b1; wt(5);
    chk(tag, got, e);
    if (a == 3'd2) begin m_det = 0; m_irq_n = 1'b1; end
    settled = 1;
  endtask

  task automatic det_pulse(input logic [7:0] v);
    settled = 0;
    det = v; wt(1); det = 8'h00; wt(2);
    m_det = m_det | v;
    if (v != 0) m_irq_n = 1'b0;
    settled = 1;
  endtask

  // detect read whose clear meets a new flag at the same clock edge
  task automatic read_race(input logic [7:0] v);
    settled = 0;
    latch(3'd2, 1'b1);
    rd_n = 1'b0; wt(5);
    chk("R6 race read data", ad_o, m_det);
    rd_n = 1'b1; wt(2);
    det = v; wt(1); det = 8'h00; wt(4);
    chk("R6 flag kept over clear irq", irq_n, 1'b0);
    m_det = v; m_irq_n = 1'b0;
    settled = 1;
  endtask

  task automatic do_reset();
    settled = 0;
    rst = 1'b1; wt(3); rst = 1'b0; wt(2);
    chk("R1 ctl0", ctl0, 0); chk("R1 ctl1", ctl1, 0);
    chk("R1 clock select default", ctl1[7], 0);
    chk("R1 tone", tone, 0); chk("R1 irq_n", irq_n, 1);
    chk("R1 oe", ad_oe, 0);
    m_ctl0 = 0; m_ctl1 = 0; m_tone = 0; m_det = 0; m_irq_n = 1'b1;
    settled = 1;
  endtask

  initial begin
    wt(4);
    do_reset();
    // R2 R3 R4: bus writes and reads of each register
    par_write(3'd0, 8'h5C, 1); par_write(3'd1, 8'h81, 1); par_write(3'd3, 8'h0B, 1);
    par_read(3'd0, 1, "R4 ctl0"); par_read(3'd1, 1, "R2 ctl1"); par_read(3'd3, 1, "R2 tone");
    // R3: unselected write ignored; R4: unselected read not driven
    par_write(3'd0, 8'hFF, 0);
    par_read(3'd0, 0, "R4 unselected");
    par_read(3'd0, 1, "R3 after unselected write");
    // R2: unmapped address
    par_write(3'd6, 8'h77, 1);
    par_read(3'd6, 1, "R2 unmapped");
    // R5: detect is read-only
    par_write(3'd2, 8'hFF, 1);
    par_read(3'd2, 1, "R5 detect after write");
    // R6: sticky flags, interrupt and read-clear
    det_pulse(8'h05); det_pulse(8'h40);
    par_read(3'd2, 1, "R6 detect flags");
    par_read(3'd2, 1, "R6 detect cleared");
    det_pulse(8'h01);
    read_race(8'h02);
    par_read(3'd2, 1, "R6 race survivor");
    // R7 R8 R9: serial path
    ser_write(3'd1, 8'hA6);
    ser_read(3'd1, "R8 serial read ctl1");
    par_read(3'd1, 1, "R9 serial write seen on bus");
    ser_read(3'd0, "R8 serial read ctl0");
    ser_write(3'd2, 8'hFF);
    det_pulse(8'h18);
    ser_read(3'd2, "R5 R6 serial detect read");
    // R10: tone start
    par_write(3'd3, 8'h10, 1); par_write(3'd0, 8'h00, 1);
    par_write(3'd0, 8'h02, 1);
    chk("R10 pulse issued", pulses, 1);
    par_write(3'd0, 8'h02, 1);
    par_write(3'd0, 8'h00, 1); par_write(3'd3, 8'h00, 1);
    par_write(3'd0, 8'h02, 1);
    chk("R10 no pulse without tone mode", pulses, 1);
    par_write(3'd0, 8'h00, 1); par_write(3'd3, 8'h10, 1);
    ser_write(3'd0, 8'h02);
    chk("R10 serial write pulse", pulses, 2);
    // R1: reset in mid-run
    par_write(3'd1, 8'h80, 1);
    det_pulse(8'h20);
    do_reset();
    par_read(3'd2, 1, "R1 detect cleared by reset");
    wt(5);
    finish_run();
  end
endmodule